// File: doc/BRIEF.md
# Windowed Backplane Address Translator

This block lets a host with only a small 4 KiB aperture reach any location of a 32-bit backplane. A byte-wide configuration port holds four registers. Three of them together hold the window base, which supplies backplane address bits 31:12. The fourth is a one-bit segment selector that supplies address bit 11. Host accesses carry a 12-bit offset. Bit 11 of that offset names the segment the access needs. If the segment register holds the other value, the block rewrites the register and confirms it before it starts any backplane transfer. The segment register is cleared at reset and again by a one-cycle resume pulse.

Host accesses arrive on a valid/ready request channel. A request is taken only while `req_ready` is high, and that happens only when the block is idle. Read data leaves on a valid/ready response channel. The response stays valid and stable until `rsp_ready` is seen high at a clock edge. On the backplane side, `bp_valid` holds its address and data until `bp_ready` is high at an edge. Read data comes back as a single `bp_rvalid` beat, which the block always accepts. A 32-bit access becomes two 16-bit transfers, and the backplane only ever sees byte or 16-bit transfers. Until software has written any window register after reset, the block never touches the backplane. In that state reads return all-ones and writes are dropped.

Top module: `wbat_top`

## Requirements
- R1: Configuration offset 0x2E holds window bits 15:12 in data bits 3:0; data bits 7:4 read back as zero and are not stored.
- R2: Offset 0x30 holds window bits 23:16 and offset 0x32 holds window bits 31:24, each reading back the full byte written.
- R3: Offset 0x34 is the segment register. It stores data bit 0 only and reads back as {7'b0, segment}. All four registers read zero after reset.
- R4: A `resume` pulse clears the segment register at the next edge. This takes precedence over a configuration write in the same cycle.
- R5: A backplane transfer address is {window[31:12], segment, offset[10:0]}, so offsets 0x800 and above are served from segment 1 and lower offsets from segment 0.
- R6: When a request's offset bit 11 differs from the segment register, the block writes the needed value into the segment register and checks it before issuing. A later configuration read shows the new value, and each access still issues each transfer exactly once.
- R7: `req_size` 0 is a byte and 1 is a 16-bit access; each is a single transfer. `bp_half` is 1 for 16-bit transfers. A byte write places its data in `bp_wdata[7:0]` with bits 15:8 zero. A byte read returns {24'b0, bp_rdata[7:0]} and a 16-bit read returns {16'b0, bp_rdata}.
- R8: `req_size` 2 or 3 is a 32-bit access, made as two 16-bit transfers. The low half goes first, at the computed address. The high half follows at that full 32-bit address plus 2, even where this carries into bit 11. Read data is {high, low}.
- R9: If no window register has been written since reset, no backplane transfer is made. Reads return 0x000000FF, 0x0000FFFF or 0xFFFFFFFF by size, and writes are dropped.
- R10: A configuration write takes effect at the clock edge where `cfg_we` is sampled. `cfg_rdata` is combinational and shows the old value before that edge and the new value after it.
- R11: `req_ready` is high only when idle. `bp_valid` with its address holds until `bp_ready`. `rsp_valid` with its data holds until `rsp_ready`.
- R12: Configuration offsets other than the four registers read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| resume | input | 1 | One-cycle pulse that clears the segment register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read-back of the addressed register |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 or 3 32-bit |
| req_off | input | 12 | Host aperture offset |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read response data |
| bp_valid | output | 1 | Backplane transfer valid |
| bp_ready | input | 1 | Backplane accepts the transfer |
| bp_write | output | 1 | Transfer is a write |
| bp_half | output | 1 | 1 = 16-bit transfer, 0 = byte |
| bp_addr | output | 32 | Backplane byte address |
| bp_wdata | output | 16 | Transfer write data |
| bp_rvalid | input | 1 | Read data beat from the backplane |
| bp_rdata | input | 16 | Read data from the backplane |

## Verification
The hardest case to reach from the ports is a 32-bit access whose high half carries across the 2 KiB segment boundary. It arrives while the segment register holds the opposite value, so an automatic segment switch and a carry into bit 11 happen in the same access. The stimulus gets there by setting the segment through the configuration port to the value opposite the one the offset needs, then issuing a word read at offset 0x7FE. The bench then checks the switch, both transfer addresses and their order. Back-pressure is exercised by letting the backplane model toggle `bp_ready` every cycle and by holding `rsp_ready` low for several cycles. This shows that no transfer is duplicated and that the response stays frozen while it waits.

// File: rtl/wbat_pkg.sv
package wbat_pkg;
  localparam int unsigned BP_AW    = 32;
  localparam int unsigned HOST_OW  = 12;
  localparam int unsigned CFG_AW   = 8;
  localparam int unsigned CFG_DW   = 8;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned WORD_W   = 2 * HALF_W;
  localparam int unsigned SEG_BIT  = HOST_OW - 1;
  localparam int unsigned WIN_W    = BP_AW - HOST_OW;
  localparam int unsigned WIN0_W   = WIN_W - 2 * CFG_DW;
  localparam int unsigned LOW_OW   = HOST_OW - 1;

  localparam logic [CFG_AW-1:0] CFG_WIN_LO  = 8'h2E;
  localparam logic [CFG_AW-1:0] CFG_WIN_MID = 8'h30;
  localparam logic [CFG_AW-1:0] CFG_WIN_HI  = 8'h32;
  localparam logic [CFG_AW-1:0] CFG_SEGSEL  = 8'h34;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SWITCH, ST_LO, ST_WAIT_LO, ST_HI, ST_WAIT_HI, ST_RESP
  } xfer_state_e;

  typedef struct packed {
    logic              write;
    logic [1:0]        size;
    logic [HOST_OW-1:0] off;
    logic [WORD_W-1:0] wdata;
  } host_req_t;
endpackage

// File: rtl/wbat_cfg_regs.sv
module wbat_cfg_regs
  import wbat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resume,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              eng_seg_we,
  input  logic              eng_seg_val,
  output logic [WIN_W-1:0]  window,
  output logic              seg,
  output logic              win_set
);
  logic [WIN0_W-1:0] win_lo_q;
  logic [CFG_DW-1:0] win_mid_q;
  logic [CFG_DW-1:0] win_hi_q;
  logic              seg_q;
  logic              set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lo_q  <= '0;
      win_mid_q <= '0;
      win_hi_q  <= '0;
      set_q     <= 1'b0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        CFG_WIN_LO:  begin win_lo_q  <= cfg_wdata[WIN0_W-1:0]; set_q <= 1'b1; end
        CFG_WIN_MID: begin win_mid_q <= cfg_wdata;             set_q <= 1'b1; end
        CFG_WIN_HI:  begin win_hi_q  <= cfg_wdata;             set_q <= 1'b1; end
        default: ;
      endcase
    end
  end

  // Segment: resume first, then the configuration port, then the engine.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seg_q <= 1'b0;
    else if (resume)                              seg_q <= 1'b0;
    else if (cfg_we && cfg_addr == CFG_SEGSEL)    seg_q <= cfg_wdata[0];
    else if (eng_seg_we)                          seg_q <= eng_seg_val;
  end

  always_comb begin
    unique case (cfg_addr)
      CFG_WIN_LO:  cfg_rdata = {{(CFG_DW-WIN0_W){1'b0}}, win_lo_q};
      CFG_WIN_MID: cfg_rdata = win_mid_q;
      CFG_WIN_HI:  cfg_rdata = win_hi_q;
      CFG_SEGSEL:  cfg_rdata = {{(CFG_DW-1){1'b0}}, seg_q};
      default:     cfg_rdata = '0;
    endcase
  end

  assign window  = {win_hi_q, win_mid_q, win_lo_q};
  assign seg     = seg_q;
  assign win_set = set_q;
endmodule

// File: rtl/wbat_addr_gen.sv
module wbat_addr_gen
  import wbat_pkg::*;
(
  input  logic [WIN_W-1:0]  window,
  input  logic              seg,
  input  logic [LOW_OW-1:0] off_low,
  input  logic              hi_sel,
  output logic [BP_AW-1:0]  addr
);
  localparam logic [BP_AW-1:0] HALF_STEP = BP_AW'(HALF_W / 8);
  logic [BP_AW-1:0] base;

  assign base = {window, seg, off_low};
  assign addr = hi_sel ? base + HALF_STEP : base;
endmodule

// File: rtl/wbat_xfer_fsm.sv
module wbat_xfer_fsm
  import wbat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  host_req_t          req_in,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               bp_valid,
  input  logic               bp_ready,
  output logic               bp_write,
  output logic               bp_half,
  output logic [HALF_W-1:0]  bp_wdata,
  input  logic               bp_rvalid,
  input  logic [HALF_W-1:0]  bp_rdata,
  input  logic               seg,
  input  logic               win_set,
  output logic               eng_seg_we,
  output logic               eng_seg_val,
  output logic [LOW_OW-1:0]  off_low,
  output logic               hi_sel
);
  xfer_state_e state_q;
  host_req_t   req_q;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic need_seg, is_word;

  assign need_seg = req_q.off[SEG_BIT];
  assign is_word  = req_q.size[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          req_q <= req_in;
          if (!win_set) begin
            lo_q    <= '1;
            hi_q    <= '1;
            state_q <= req_in.write ? ST_IDLE : ST_RESP;
          end else if (req_in.off[SEG_BIT] != seg) begin
            state_q <= ST_SWITCH;
          end else begin
            state_q <= ST_LO;
          end
        end
        ST_SWITCH: if (seg == need_seg) state_q <= ST_LO;
        ST_LO: if (bp_ready) begin
          if (!req_q.write)  state_q <= ST_WAIT_LO;
          else if (is_word)  state_q <= ST_HI;
          else               state_q <= ST_IDLE;
        end
        ST_WAIT_LO: if (bp_rvalid) begin
          lo_q    <= bp_rdata;
          state_q <= is_word ? ST_HI : ST_RESP;
        end
        ST_HI: if (bp_ready) state_q <= req_q.write ? ST_IDLE : ST_WAIT_HI;
        ST_WAIT_HI: if (bp_rvalid) begin
          hi_q    <= bp_rdata;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign eng_seg_we  = (state_q == ST_SWITCH) && (seg != need_seg);
  assign eng_seg_val = need_seg;
  assign off_low     = req_q.off[LOW_OW-1:0];
  assign hi_sel      = (state_q == ST_HI);

  assign bp_valid = (state_q == ST_LO) || (state_q == ST_HI);
  assign bp_write = req_q.write;
  assign bp_half  = (req_q.size != 2'd0);

  always_comb begin
    if (hi_sel)              bp_wdata = req_q.wdata[WORD_W-1:HALF_W];
    else if (bp_half)        bp_wdata = req_q.wdata[HALF_W-1:0];
    else                     bp_wdata = {{(HALF_W-8){1'b0}}, req_q.wdata[7:0]};
  end

  assign rsp_valid = (state_q == ST_RESP);
  always_comb begin
    unique case (req_q.size)
      2'd0:    rsp_rdata = {{(WORD_W-8){1'b0}}, lo_q[7:0]};
      2'd1:    rsp_rdata = {{(WORD_W-HALF_W){1'b0}}, lo_q};
      default: rsp_rdata = {hi_q, lo_q};
    endcase
  end
endmodule

// File: rtl/wbat_top.sv
module wbat_top
  import wbat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                resume,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  output logic [CFG_DW-1:0]   cfg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [HOST_OW-1:0]  req_off,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                bp_valid,
  input  logic                bp_ready,
  output logic                bp_write,
  output logic                bp_half,
  output logic [BP_AW-1:0]    bp_addr,
  output logic [HALF_W-1:0]   bp_wdata,
  input  logic                bp_rvalid,
  input  logic [HALF_W-1:0]   bp_rdata
);
  logic [WIN_W-1:0]  window_w;
  logic              seg_q;
  logic              win_set_w;
  logic              eng_seg_we, eng_seg_val;
  logic [LOW_OW-1:0] off_low;
  logic              hi_sel;
  host_req_t         req_in;

  assign req_in = '{write: req_write, size: req_size, off: req_off, wdata: req_wdata};

  wbat_cfg_regs u_regs (
    .clk, .rst_n, .resume,
    .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .eng_seg_we, .eng_seg_val,
    .window(window_w), .seg(seg_q), .win_set(win_set_w)
  );

  wbat_xfer_fsm u_fsm (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_in,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .bp_valid, .bp_ready, .bp_write, .bp_half, .bp_wdata,
    .bp_rvalid, .bp_rdata,
    .seg(seg_q), .win_set(win_set_w),
    .eng_seg_we, .eng_seg_val, .off_low, .hi_sel
  );

  wbat_addr_gen u_addr (
    .window(window_w), .seg(seg_q), .off_low, .hi_sel, .addr(bp_addr)
  );
endmodule

// File: rtl/wbat_sva.sv
module wbat_sva
  import wbat_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               resume,
  input logic [CFG_AW-1:0]  cfg_addr,
  input logic [CFG_DW-1:0]  cfg_rdata,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [WORD_W-1:0]  rsp_rdata,
  input logic               bp_valid,
  input logic               bp_ready,
  input logic [BP_AW-1:0]   bp_addr,
  input logic [WIN_W-1:0]   window,
  input logic               seg,
  input logic               win_set
);
  AST_WIN0_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == CFG_WIN_LO |-> cfg_rdata[7:WIN0_W] == '0); // R1

  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !seg); // R4

  AST_ADDR_COMPOSE: assert property (@(posedge clk) disable iff (!rst_n)
    bp_valid && bp_addr[LOW_OW-1:1] != '0 |->
      bp_addr[BP_AW-1:HOST_OW] == window && bp_addr[SEG_BIT] == seg); // R5

  AST_NO_XFER_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
    !win_set |-> !bp_valid); // R9

  AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bp_valid && !bp_ready |=> bp_valid && $stable(bp_addr)); // R11

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11

  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bp_valid && !rsp_valid); // R11
endmodule

bind wbat_top wbat_sva u_sva (
  .clk(clk), .rst_n(rst_n), .resume(resume),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .bp_valid(bp_valid), .bp_ready(bp_ready),
  .bp_addr(bp_addr), .window(window_w), .seg(seg_q), .win_set(win_set_w)
);

// File: tb/wbat_top_tb_top.sv
`timescale 1ns/1ps
module wbat_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resume = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0] req_size = '0;
  logic [11:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic bp_valid, bp_ready = 1'b1, bp_write, bp_half;
  logic [31:0] bp_addr;
  logic [15:0] bp_wdata;
  logic bp_rvalid = 1'b0;
  logic [15:0] bp_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  bit stall_en = 0;
  int unsigned xfer_cnt = 0;
  logic [31:0] lg_addr [4];
  logic [15:0] lg_wdata[4];
  logic        lg_write[4];
  logic        lg_half [4];

  always #2.5 clk = ~clk;

  wbat_top dut_i (.*);

  function automatic logic [15:0] mdl(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  // Backplane model: ready toggles when stalling, read data one cycle later.
  always @(posedge clk) begin
    bp_ready  <= stall_en ? ~bp_ready : 1'b1;
    bp_rvalid <= 1'b0;
    if (bp_valid && bp_ready) begin
      lg_addr [xfer_cnt[1:0]] <= bp_addr;
      lg_wdata[xfer_cnt[1:0]] <= bp_wdata;
      lg_write[xfer_cnt[1:0]] <= bp_write;
      lg_half [xfer_cnt[1:0]] <= bp_half;
      xfer_cnt <= xfer_cnt + 1;
      if (!bp_write) begin
        bp_rvalid <= 1'b1;
        bp_rdata  <= mdl(bp_addr);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic host(input logic wr, input logic [1:0] sz, input logic [11:0] off,
                      input logic [31:0] wd, output logic [31:0] rd);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_off = off; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    rd = 'x;
    if (!wr) begin
      guard = 0;
      while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
      rd = rsp_rdata;
      if (!rsp_ready) begin
        @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset_and_unset();
    logic [7:0] v; logic [31:0] r; int unsigned n0;
    cfg_rd(8'h2E, v); chk("R3 reset win lo", {24'h0, v}, 32'h0);
    cfg_rd(8'h30, v); chk("R3 reset win mid", {24'h0, v}, 32'h0);
    cfg_rd(8'h32, v); chk("R3 reset win hi", {24'h0, v}, 32'h0);
    cfg_rd(8'h34, v); chk("R3 reset seg", {24'h0, v}, 32'h0);
    chk("R11 idle ready", {31'h0, req_ready}, 32'h1);
    n0 = xfer_cnt;
    host(1'b0, 2'd2, 12'h100, 0, r); chk("R9 word ones", r, 32'hFFFF_FFFF);
    host(1'b0, 2'd0, 12'h101, 0, r); chk("R9 byte ones", r, 32'h0000_00FF);
    host(1'b0, 2'd1, 12'h900, 0, r); chk("R9 half ones", r, 32'h0000_FFFF);
    host(1'b1, 2'd1, 12'h102, 32'h1234, r);
    chk("R9 no transfer", xfer_cnt - n0, 0);
    cfg_rd(8'h34, v); chk("R9 seg untouched", {24'h0, v}, 32'h0);
  endtask

  task automatic t_cfg_regs();
    logic [7:0] v;
    cfg_wr(8'h2E, 8'hA7); cfg_rd(8'h2E, v); chk("R1 win lo nibble", {24'h0, v}, 32'h07);
    cfg_wr(8'h30, 8'h12); cfg_rd(8'h30, v); chk("R2 win mid", {24'h0, v}, 32'h12);
    cfg_wr(8'h32, 8'h9C); cfg_rd(8'h32, v); chk("R2 win hi", {24'h0, v}, 32'h9C);
    cfg_wr(8'h34, 8'h03); cfg_rd(8'h34, v); chk("R3 seg bit0", {24'h0, v}, 32'h01);
    cfg_wr(8'h34, 8'h02); cfg_rd(8'h34, v); chk("R3 seg only bit0", {24'h0, v}, 32'h00);
    cfg_wr(8'h40, 8'hFF); cfg_rd(8'h40, v); chk("R12 unmapped zero", {24'h0, v}, 32'h00);
    cfg_rd(8'h2E, v); chk("R12 win lo unchanged", {24'h0, v}, 32'h07);
    cfg_rd(8'h34, v); chk("R12 seg unchanged", {24'h0, v}, 32'h00);
    // R10: old value before the edge, new value after it
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h34; cfg_wdata = 8'h01;
    #1 chk("R10 before edge", {24'h0, cfg_rdata}, 32'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 chk("R10 after edge", {24'h0, cfg_rdata}, 32'h1);
  endtask

  task automatic t_resume();
    logic [7:0] v;
    cfg_rd(8'h34, v); chk("R4 seg set first", {24'h0, v}, 32'h1);
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
    cfg_rd(8'h34, v); chk("R4 resume clears", {24'h0, v}, 32'h0);
    @(negedge clk); resume = 1'b1; cfg_we = 1'b1; cfg_addr = 8'h34; cfg_wdata = 8'h01;
    @(negedge clk); resume = 1'b0; cfg_we = 1'b0;
    cfg_rd(8'h34, v); chk("R4 resume beats write", {24'h0, v}, 32'h0);
  endtask

  task automatic t_segments();
    logic [7:0] v; logic [31:0] r; int unsigned n0;
    n0 = xfer_cnt;
    host(1'b0, 2'd1, 12'h124, 0, r);
    chk("R5 seg0 addr", lg_addr[n0[1:0]], 32'h9C12_7124);
    chk("R7 half read data", r, {16'h0, mdl(32'h9C12_7124)});
    chk("R7 half flag", {31'h0, lg_half[n0[1:0]]}, 32'h1);
    n0 = xfer_cnt;
    host(1'b0, 2'd1, 12'h9A6, 0, r);
    chk("R6 one transfer", xfer_cnt - n0, 1);
    chk("R5 seg1 addr", lg_addr[n0[1:0]], 32'h9C12_79A6);
    cfg_rd(8'h34, v); chk("R6 seg now 1", {24'h0, v}, 32'h1);
    n0 = xfer_cnt;
    host(1'b0, 2'd0, 12'h011, 0, r);
    chk("R6 back to seg0 addr", lg_addr[n0[1:0]], 32'h9C12_7011);
    chk("R7 byte read data", r, {24'h0, mdl(32'h9C12_7011) & 16'h00FF});
    cfg_rd(8'h34, v); chk("R6 seg now 0", {24'h0, v}, 32'h0);
    n0 = xfer_cnt;
    host(1'b1, 2'd0, 12'h803, 32'h0000_BEEF, r);
    chk("R7 byte write addr", lg_addr[n0[1:0]], 32'h9C12_7803);
    chk("R7 byte lane", {16'h0, lg_wdata[n0[1:0]]}, 32'h0000_00EF);
    chk("R7 byte flag", {31'h0, lg_half[n0[1:0]]}, 32'h0);
    chk("R7 write flag", {31'h0, lg_write[n0[1:0]]}, 32'h1);
  endtask

  task automatic t_words();
    logic [31:0] r; int unsigned n0;
    n0 = xfer_cnt;
    host(1'b0, 2'd2, 12'h7FC, 0, r);
    chk("R8 two transfers", xfer_cnt - n0, 2);
    chk("R8 low first", lg_addr[n0[1:0]], 32'h9C12_77FC);
    chk("R8 high plus2", lg_addr[2'(n0 + 1)], 32'h9C12_77FE);
    chk("R8 word data", r, {mdl(32'h9C12_77FE), mdl(32'h9C12_77FC)});
    n0 = xfer_cnt;
    host(1'b1, 2'd3, 12'h0A0, 32'h1234_ABCD, r);
    chk("R8 write low half", {lg_addr[n0[1:0]][15:0], lg_wdata[n0[1:0]]}, 32'h70A0_ABCD);
    chk("R8 write high half", {lg_addr[2'(n0 + 1)][15:0], lg_wdata[2'(n0 + 1)]}, 32'h70A2_1234);
    // seg set to 1 first, then a word at 0x7FE forces a switch and a carry
    cfg_wr(8'h34, 8'h01);
    n0 = xfer_cnt;
    host(1'b0, 2'd2, 12'h7FE, 0, r);
    chk("R8 boundary transfers", xfer_cnt - n0, 2);
    chk("R8 boundary low", lg_addr[n0[1:0]], 32'h9C12_77FE);
    chk("R8 boundary high carry", lg_addr[2'(n0 + 1)], 32'h9C12_7800);
    chk("R8 boundary data", r, {mdl(32'h9C12_7800), mdl(32'h9C12_77FE)});
  endtask

  task automatic t_backpressure();
    logic [31:0] r, held; int unsigned n0; int guard;
    stall_en = 1;
    n0 = xfer_cnt;
    host(1'b0, 2'd2, 12'h350, 0, r);
    chk("R11 stalled transfers", xfer_cnt - n0, 2);
    chk("R11 stalled data", r, {mdl(32'h9C12_7352), mdl(32'h9C12_7350)});
    stall_en = 0;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd1; req_off = 12'h066;
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk); req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    chk("R11 rsp held valid", {31'h0, rsp_valid}, 32'h1);
    chk("R11 rsp held data", rsp_rdata, held);
    chk("R11 not ready while holding", {31'h0, req_ready}, 32'h0);
    chk("R11 held value", held, {16'h0, mdl(32'h9C12_7066)});
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 rsp released", {31'h0, rsp_valid}, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_unset();
    t_cfg_regs();
    t_resume();
    t_segments();
    t_words();
    t_backpressure();
    finish_run();
  end
endmodule